// File: doc/BRIEF.md
# Hold-Based Shared Memory Window Arbiter

This block lets a requesting processor reach the private RAM of a second processor when no true dual-ported memory is present. When the requester starts a read or write that decodes to the shared window, the block asks the owning processor to hold its bus. Once hold acknowledge returns, it waits a settling delay and then opens the address and data buffers that join the two buses.

After a second delay it drives a local read or write strobe onto the owner's memory bus. The requester is kept in wait until that strobe has been active for a third delay. When the requester drops its strobe, the block closes the buffers first and releases the hold one clock later. Because the owner is held for the whole transfer, every shared access stalls both processors.

All delays are counted in system clocks. The parameter `DLY` sets the length of each delay. The local strobes leave the block as a value plus an output-enable pair, which a pad cell turns into a three-state line.

Top module: `hold_share_arb`

## Requirements
- R1: While reset is held and right after it, hold is low, both buffer enables are low, the strobe output-enable and both local strobes are low, and ready is high.
- R2: A read or write strobe with the window decode low never raises hold, and it leaves ready high.
- R3: A strobe with the window decode high raises hold at the next clock edge, and hold stays high while the access continues.
- R4: The address and data buffer enables are always equal. They are high only while hold and hold acknowledge are both high and the sequencing stage is complete. They first rise on the (DLY+1)th clock edge after hold acknowledge is first sampled high.
- R5: The data direction output equals the requester's read strobe: 1 means data flows toward the requester (read), 0 means toward the owner's memory (write).
- R6: The local strobe matching the access type (read strobe for a read, write strobe for a write) rises DLY clock edges after the buffers open. It falls in the same cycle that the requester's strobe falls.
- R7: The strobe output-enable equals the buffer enable, and both local strobes are low whenever the output-enable is low.
- R8: Ready is low from the cycle the windowed access starts until the local strobe has been high for DLY clock edges. It returns high in the same cycle that the requester's strobe drops.
- R9: After the requester's strobe drops, the buffers close at the next clock edge and hold falls one edge after that, so the enables are always off before hold is released.
- R10: If the access ends before hold acknowledge arrives, the buffers never open and hold falls on the second edge after the strobe drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also serves as the delay time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 1 | Requester address decodes to the shared window |
| ext_rd | input | 1 | Requester read strobe, active high |
| ext_wr | input | 1 | Requester write strobe, active high |
| hlda | input | 1 | Hold acknowledge from the owning processor |
| hold | output | 1 | Hold request to the owning processor |
| addr_buf_en | output | 1 | Enable for the address buffers between the buses |
| data_buf_en | output | 1 | Enable for the data transceiver between the buses |
| data_dir | output | 1 | Transceiver direction, 1 toward the requester |
| loc_rd | output | 1 | Local read strobe value on the owner's bus |
| loc_wr | output | 1 | Local write strobe value on the owner's bus |
| loc_oe | output | 1 | Output-enable for the local strobe drivers |
| ready | output | 1 | Ready to the requester, low inserts wait states |

## Verification
The checker watches on every cycle that the buffers open only under hold plus acknowledge, that the two enables agree, that the local strobes stay quiet while undriven, that ready is never granted without an active local strobe, and that hold never falls while the buffers are open. The exact cycle counts cannot be shown by these per-cycle properties. These are the settling delay after acknowledge, the strobe delay after the buffers open, the wait length, and the order of the release steps. Only the bench's scenarios can show them, under varying acknowledge latency, read and write mixes, out-of-window traffic and aborted requests.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_SYNC = 3'd2,
    ST_BUS  = 3'd3,
    ST_STRB = 3'd4,
    ST_DONE = 3'd5,
    ST_REL  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/hsa_seq.sv
module hsa_seq
  import hsa_pkg::*;
#(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic hlda,
  output logic hold,
  output logic grant_flag,
  output logic strb_flag,
  output logic done_flag
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DLY - 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en, cnt_last, counting;

  assign cnt_last = (cnt_q == CNT_LAST);
  assign counting = (state_q == ST_SYNC) || (state_q == ST_BUS) ||
                    (state_q == ST_STRB);

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (access) state_d = ST_REQ;
      ST_REQ:  if (!access) state_d = ST_REL;
               else if (hlda) state_d = ST_SYNC;
      ST_SYNC: if (!access) state_d = ST_REL;
               else if (cnt_last) state_d = ST_BUS;
      ST_BUS:  if (!access) state_d = ST_REL;
               else if (cnt_last) state_d = ST_STRB;
      ST_STRB: if (!access) state_d = ST_REL;
               else if (cnt_last) state_d = ST_DONE;
      ST_DONE: if (!access) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // delay counter: restart on each phase change, advance inside timed phases
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_d != state_q) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (counting) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hold       = (state_q != ST_IDLE);
  assign grant_flag = (state_q == ST_BUS) || (state_q == ST_STRB) ||
                      (state_q == ST_DONE);
  assign strb_flag  = (state_q == ST_STRB) || (state_q == ST_DONE);
  assign done_flag  = (state_q == ST_DONE);
endmodule

// File: rtl/hsa_outs.sv
module hsa_outs (
  input  logic hold,
  input  logic hlda,
  input  logic grant_flag,
  input  logic strb_flag,
  input  logic done_flag,
  input  logic access,
  input  logic ext_rd,
  input  logic ext_wr,
  output logic buf_en,
  output logic data_dir,
  output logic loc_rd,
  output logic loc_wr,
  output logic loc_oe,
  output logic ready
);
  // buffers open only when the owner has yielded its bus
  assign buf_en   = grant_flag & hold & hlda;
  assign data_dir = ext_rd;
  assign loc_oe   = buf_en;
  assign loc_rd   = buf_en & strb_flag & ext_rd;
  assign loc_wr   = buf_en & strb_flag & ext_wr;
  assign ready    = ~access | (done_flag & buf_en);
endmodule

// File: rtl/hold_share_arb.sv
module hold_share_arb #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_sel,
  input  logic ext_rd,
  input  logic ext_wr,
  input  logic hlda,
  output logic hold,
  output logic addr_buf_en,
  output logic data_buf_en,
  output logic data_dir,
  output logic loc_rd,
  output logic loc_wr,
  output logic loc_oe,
  output logic ready
);
  logic access, grant_flag, strb_flag, done_flag, buf_en;

  assign access = win_sel & (ext_rd | ext_wr);

  hsa_seq #(.DLY(DLY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .access     (access),
    .hlda       (hlda),
    .hold       (hold),
    .grant_flag (grant_flag),
    .strb_flag  (strb_flag),
    .done_flag  (done_flag)
  );

  hsa_outs u_outs (
    .hold       (hold),
    .hlda       (hlda),
    .grant_flag (grant_flag),
    .strb_flag  (strb_flag),
    .done_flag  (done_flag),
    .access     (access),
    .ext_rd     (ext_rd),
    .ext_wr     (ext_wr),
    .buf_en     (buf_en),
    .data_dir   (data_dir),
    .loc_rd     (loc_rd),
    .loc_wr     (loc_wr),
    .loc_oe     (loc_oe),
    .ready      (ready)
  );

  assign addr_buf_en = buf_en;
  assign data_buf_en = buf_en;
endmodule

// File: rtl/hold_share_arb_chk.sv
module hold_share_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic win_sel,
  input logic ext_rd,
  input logic ext_wr,
  input logic hlda,
  input logic hold,
  input logic addr_buf_en,
  input logic data_buf_en,
  input logic loc_rd,
  input logic loc_wr,
  input logic loc_oe,
  input logic ready
);
  p_buf_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_buf_en |-> (hold && hlda));

  p_buf_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_buf_en == data_buf_en);

  p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_oe |-> (!loc_rd && !loc_wr));

  p_oe_tracks_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_oe |-> addr_buf_en);

  p_ready_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && win_sel && (ext_rd || ext_wr)) |-> (loc_rd || loc_wr));

  p_outside_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_sel |-> ready);

  p_hold_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && win_sel && (ext_rd || ext_wr)) |=> hold);

  p_release_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> !$past(addr_buf_en));
endmodule

bind hold_share_arb hold_share_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_sel     (win_sel),
  .ext_rd      (ext_rd),
  .ext_wr      (ext_wr),
  .hlda        (hlda),
  .hold        (hold),
  .addr_buf_en (addr_buf_en),
  .data_buf_en (data_buf_en),
  .loc_rd      (loc_rd),
  .loc_wr      (loc_wr),
  .loc_oe      (loc_oe),
  .ready       (ready)
);

// File: tb/sim_hold_share_arb.sv
`timescale 1ns/1ps
module sim_hold_share_arb;
  localparam int DLY = 4;

  logic clk, rst_n, win_sel, ext_rd, ext_wr, hlda;
  logic hold, addr_buf_en, data_buf_en, data_dir, loc_rd, loc_wr, loc_oe, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  hold_share_arb #(.DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .hlda(hlda), .hold(hold), .addr_buf_en(addr_buf_en),
    .data_buf_en(data_buf_en), .data_dir(data_dir), .loc_rd(loc_rd),
    .loc_wr(loc_wr), .loc_oe(loc_oe), .ready(ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected strobe for a given access type, computed from R6
  function automatic int exp_loc(input bit want_wr, input bit is_wr, input bit active);
    return (active && (want_wr == is_wr)) ? 1 : 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic windowed(input bit is_wr, input int lat, input int extra);
    win_sel = 1'b1; ext_rd = !is_wr; ext_wr = is_wr;
    #0.1;
    chk(ready, 0, "R8", "ready at access start");
    chk(data_dir, is_wr ? 0 : 1, "R5", "direction");
    tick();
    chk(hold, 1, "R3", "hold after first edge");
    for (int i = 0; i < lat; i++) begin
      tick();
      chk(addr_buf_en, 0, "R4", "buffers closed before ack");
    end
    hlda = 1'b1;
    for (int i = 0; i < DLY; i++) begin
      tick();
      chk(addr_buf_en, 0, "R4", "buffers closed during settle");
    end
    tick();
    chk(addr_buf_en, 1, "R4", "buffers open at DLY+1");
    chk(data_buf_en, addr_buf_en, "R4", "enable pair");
    chk(loc_oe, 1, "R7", "strobe drive on");
    for (int i = 0; i < DLY - 1; i++) begin
      tick();
      chk(loc_rd | loc_wr, 0, "R6", "strobe still low");
      chk(ready, 0, "R8", "waiting before strobe");
    end
    tick();
    chk(loc_rd, exp_loc(0, is_wr, 1), "R6", "local read");
    chk(loc_wr, exp_loc(1, is_wr, 1), "R6", "local write");
    for (int i = 0; i < DLY - 1; i++) begin
      tick();
      chk(ready, 0, "R8", "waiting during strobe");
    end
    tick();
    chk(ready, 1, "R8", "ready after strobe delay");
    for (int i = 0; i < extra; i++) begin
      tick();
      chk(ready, 1, "R8", "ready held");
      chk(hold, 1, "R3", "hold held");
    end
    ext_rd = 1'b0; ext_wr = 1'b0;
    #0.1;
    chk(loc_rd | loc_wr, 0, "R6", "strobe follows drop");
    chk(ready, 1, "R8", "ready on drop");
    tick();
    chk(addr_buf_en, 0, "R9", "buffers close first");
    chk(loc_oe, 0, "R7", "strobe drive off");
    chk(hold, 1, "R9", "hold still up");
    tick();
    chk(hold, 0, "R9", "hold released");
    hlda = 1'b0; win_sel = 1'b0;
  endtask

  task automatic outside(input int n);
    win_sel = 1'b0; ext_rd = ($urandom & 1) != 0; ext_wr = !ext_rd;
    for (int i = 0; i < n; i++) begin
      tick();
      chk(hold, 0, "R2", "no hold outside window");
      chk(ready, 1, "R2", "ready outside window");
    end
    ext_rd = 1'b0; ext_wr = 1'b0;
  endtask

  task automatic abort_early();
    win_sel = 1'b1; ext_rd = 1'b1; ext_wr = 1'b0;
    tick();
    chk(hold, 1, "R10", "hold raised");
    ext_rd = 1'b0;
    tick();
    chk(hold, 1, "R10", "hold one more edge");
    chk(addr_buf_en, 0, "R10", "no buffers");
    tick();
    chk(hold, 0, "R10", "hold dropped");
    chk(addr_buf_en, 0, "R10", "never opened");
    win_sel = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; win_sel = 1'b0; ext_rd = 1'b0; ext_wr = 1'b0; hlda = 1'b0;
    repeat (3) tick();
    chk(hold, 0, "R1", "reset hold");
    chk(addr_buf_en | data_buf_en, 0, "R1", "reset buffers");
    chk(loc_oe | loc_rd | loc_wr, 0, "R1", "reset strobes");
    chk(ready, 1, "R1", "reset ready");
    rst_n = 1'b1;
    tick();
    chk(hold, 0, "R1", "idle after reset");
    windowed(0, 0, 0);
    windowed(1, 3, 2);
    abort_early();
    outside(4);
    for (int n = 0; n < 40; n++) begin
      case ($urandom % 4)
        0: outside(1 + $urandom % 3);
        1: abort_early();
        default: windowed(($urandom & 1) != 0, $urandom % 5, $urandom % 4);
      endcase
      repeat ($urandom % 3) tick();
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule